// File: doc/BRIEF.md
# Pulse-Burst Tape Playback Decoder

This block sits behind the playback filter of a simple audio recorder. It takes the squared and inverted playback signal, in which every falling edge is one tone pulse, and recovers the nibbles stored on tape. Each nibble is a burst of between one and sixteen pulses. A silence longer than three pulse periods marks the boundary between nibbles. Pairs of nibbles form bytes. The record starts with two start words. A buffer segment ends with three identical stop words, and a different triple marks the end of the whole record.

Playback runs from reset. The block keeps the recorder motor enabled while it reads and stores every nibble of the segment. On the closing triple it turns the motor off. It then checks the segment: both start words must be present, no burst may be malformed and the store must not have overflowed. A good segment is replayed in order as 8-bit words that carry the nibble in the low half and zero in the high half, ready for a byte-oriented serial link. A bad segment is flagged and nothing is replayed. The next segment needs a new reset.

Top module: `tape_burst_decoder`

## Requirements
- R1: `tape_in` passes through two synchronizing flops. Each falling edge of the synchronized signal counts as one pulse. A pulse is low for at least two clocks and high for at least two clocks.
- R2: A burst closes once more than GAP_LIM clocks (default 12, three pulse periods of 4) pass without a counted edge. A burst of N pulses (N from 1 to 16) yields the nibble N-1.
- R3: Nibbles pair into bytes, and the first nibble of each pair is the high half.
- R4: `motor_on` is high from reset. It falls in the cycle that `buf_end` pulses and stays low until the next reset.
- R5: Three consecutive bytes equal to 8'hF0 end the segment with a one-cycle `buf_end` and no `rec_end`. A run broken by any other byte starts again from zero.
- R6: Three consecutive bytes equal to 8'hFE end the segment with `buf_end` and `rec_end` pulsing together.
- R7: A segment is valid only if its first two bytes are 8'hA5, it had no framing error and it did not overflow.
- R8: After a valid segment ends, every stored nibble, framing bytes included, appears in arrival order as `out_data` = {4'h0, nibble}, one per clock with `out_valid`. No word appears while `motor_on` is high.
- R9: An invalid segment pulses `buf_bad` together with `buf_end` and produces no `out_valid`.
- R10: A burst of more than 16 pulses sets `frame_err`, which holds until reset. The burst yields no nibble and does not disturb the pairing.
- R11: Bursts that arrive after the segment has ended change neither the outputs nor `frame_err`.
- R12: A segment holding more than NIB_DEPTH nibbles (default 368) is invalid. Exactly NIB_DEPTH nibbles is still valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, starts a new segment |
| tape_in | input | 1 | Squared, inverted playback signal (idle high) |
| motor_on | output | 1 | Recorder motor enable |
| out_valid | output | 1 | Replayed word present |
| out_data | output | 8 | Replayed word, nibble in bits 3:0 |
| buf_end | output | 1 | One-cycle pulse at segment end |
| rec_end | output | 1 | One-cycle pulse when the end-of-record triple closed the segment |
| buf_bad | output | 1 | One-cycle pulse when the ended segment failed validation |
| frame_err | output | 1 | Sticky: an overlong burst was seen |

## Verification
The properties assume the playback signal keeps the timing of R1 and R2. Pulses inside a burst must be closer together than the gap limit, and the silence between bursts must be clearly longer than the limit plus the two-flop delay. Only under those conditions do counted pulses match the bursts that were recorded. The stimulus drives every pulse low for two clocks and high for two, and leaves a 20-clock silence after each burst. It keeps the input high through every reset, so the synchronizer never reports a false edge when reset is released.

// File: rtl/tpd_pkg.sv
package tpd_pkg;
    localparam int NIB_W      = 4;
    localparam int MAX_PULSES = 1 << NIB_W;

    typedef logic [NIB_W-1:0] nibble_t;

    typedef enum logic [0:0] {
        SEG_READ = 1'b0,
        SEG_OVER = 1'b1
    } seg_state_e;
endpackage

// File: rtl/tpd_sync.sv
module tpd_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tape_in,
    output logic fall_o
);
    typedef struct packed {
        logic m1;
        logic m2;
        logic m3;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d    = q;
        d.m1 = tape_in;
        d.m2 = q.m1;
        d.m3 = q.m2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{m1: 1'b1, m2: 1'b1, m3: 1'b1};
        else        q <= d;
    end

    // edge seen between the second and third stage
    assign fall_o = q.m3 & ~q.m2;

    assert_edge_is_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/tpd_burst.sv
module tpd_burst
    import tpd_pkg::*;
#(
    parameter int GAP_LIM = 12
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    fall_i,
    output logic    nib_v_o,
    output nibble_t nib_o,
    output logic    nib_err_o
);
    localparam int CNT_W = $clog2(MAX_PULSES + 2);
    localparam int GAP_W = $clog2(GAP_LIM + 1);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_PULSES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_PULSES);
    localparam logic [GAP_W-1:0] GAP_V   = GAP_W'(GAP_LIM);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic [GAP_W-1:0] gap;
        logic             nib_v;
        nibble_t          nib;
        logic             err;
    } burst_t;

    burst_t q, d;
    logic [CNT_W-1:0] cnt_m1;

    always_comb begin
        d       = q;
        d.nib_v = 1'b0;
        d.err   = 1'b0;
        cnt_m1  = q.cnt - 1'b1;
        if (fall_i) begin
            d.active = 1'b1;
            d.gap    = '0;
            if (q.cnt != CNT_SAT) d.cnt = q.cnt + 1'b1;
        end else if (q.active) begin
            if (q.gap == GAP_V) begin
                d.active = 1'b0;
                d.gap    = '0;
                d.cnt    = '0;
                d.nib_v  = 1'b1;
                if (q.cnt > CNT_MAX) d.err = 1'b1;
                else                 d.nib = cnt_m1[NIB_W-1:0];
            end else begin
                d.gap = q.gap + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign nib_v_o   = q.nib_v;
    assign nib_o     = q.nib;
    assign nib_err_o = q.err;

    assert_close_on_silence_R2: assert property (@(posedge clk) disable iff (!rst_n)
        nib_v_o |-> $past(!fall_i));
    assert_idle_after_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
        nib_v_o |=> !nib_v_o);
endmodule

// File: rtl/tpd_frame.sv
module tpd_frame
    import tpd_pkg::*;
#(
    parameter logic [7:0] START_CODE = 8'hA5,
    parameter logic [7:0] STOP_CODE  = 8'hF0,
    parameter logic [7:0] END_CODE   = 8'hFE
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    nib_v_i,
    input  nibble_t nib_i,
    input  logic    nib_err_i,
    output logic    accept_o,
    output logic    reading_o,
    output logic    done_o,
    output logic    ok_o,
    output logic    rec_o,
    output logic    ferr_o
);
    typedef struct packed {
        seg_state_e st;
        logic       half;
        nibble_t    hi;
        logic [1:0] bidx;
        logic       start_bad;
        logic       ferr;
        logic [1:0] srun;
        logic [1:0] erun;
        logic       done;
        logic       rec;
    } frame_t;

    frame_t q, d;
    logic [7:0] byte_w;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        byte_w = {q.hi, nib_i};
        if (q.st == SEG_READ && nib_v_i) begin
            if (nib_err_i) begin
                d.ferr = 1'b1;
            end else if (!q.half) begin
                d.half = 1'b1;
                d.hi   = nib_i;
            end else begin
                d.half = 1'b0;
                if (q.bidx != 2'd2) begin
                    d.bidx = q.bidx + 1'b1;
                    if (byte_w != START_CODE) d.start_bad = 1'b1;
                end
                if (byte_w == STOP_CODE) begin
                    if (q.srun == 2'd2) begin
                        d.done = 1'b1;
                        d.st   = SEG_OVER;
                        d.rec  = 1'b0;
                    end else begin
                        d.srun = q.srun + 1'b1;
                    end
                end else begin
                    d.srun = '0;
                end
                if (byte_w == END_CODE) begin
                    if (q.erun == 2'd2) begin
                        d.done = 1'b1;
                        d.st   = SEG_OVER;
                        d.rec  = 1'b1;
                    end else begin
                        d.erun = q.erun + 1'b1;
                    end
                end else begin
                    d.erun = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: SEG_READ, hi: '0, bidx: '0, srun: '0, erun: '0, default: 1'b0};
        else        q <= d;
    end

    assign accept_o  = (q.st == SEG_READ) & nib_v_i & ~nib_err_i;
    assign reading_o = (q.st == SEG_READ);
    assign done_o    = q.done;
    assign ok_o      = ~q.start_bad & ~q.ferr & (q.bidx == 2'd2);
    assign rec_o     = q.rec;
    assign ferr_o    = q.ferr;

    assert_motor_stays_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !reading_o |=> !reading_o);
    assert_end_stops_motor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!reading_o && $past(reading_o)));
    assert_ferr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ferr_o |=> ferr_o);
    assert_ignored_after_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !reading_o |=> $stable(ferr_o));
endmodule

// File: rtl/tpd_store.sv
module tpd_store
    import tpd_pkg::*;
#(
    parameter int DEPTH = 368
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr_en_i,
    input  nibble_t wr_nib_i,
    input  logic    go_i,
    output logic    ovf_o,
    output logic    out_v_o,
    output nibble_t out_nib_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic          ovf;
        logic          rd_act;
        logic [PW-1:0] rptr;
    } store_t;

    store_t  q, d;
    nibble_t mem [DEPTH];

    always_comb begin
        d = q;
        if (wr_en_i) begin
            if (q.wptr == DEPTH_V) d.ovf = 1'b1;
            else                   d.wptr = q.wptr + 1'b1;
        end
        if (q.rd_act) begin
            if (q.rptr == q.wptr - 1'b1) d.rd_act = 1'b0;
            else                         d.rptr = q.rptr + 1'b1;
        end else if (go_i && q.wptr != '0) begin
            d.rd_act = 1'b1;
            d.rptr   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (wr_en_i && q.wptr != DEPTH_V) mem[q.wptr[AW-1:0]] <= wr_nib_i;
    end

    assign ovf_o     = q.ovf;
    assign out_v_o   = q.rd_act;
    assign out_nib_o = mem[q.rptr[AW-1:0]];

    assert_replay_in_bounds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_v_o |-> (q.rptr < q.wptr));
    assert_overflow_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);
endmodule

// File: rtl/tape_burst_decoder.sv
module tape_burst_decoder
    import tpd_pkg::*;
#(
    parameter int         PULSE_PER   = 4,
    parameter int         GAP_PERIODS = 3,
    parameter int         MAX_BYTES   = 184,
    parameter logic [7:0] START_CODE  = 8'hA5,
    parameter logic [7:0] STOP_CODE   = 8'hF0,
    parameter logic [7:0] END_CODE    = 8'hFE
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tape_in,
    output logic       motor_on,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       buf_end,
    output logic       rec_end,
    output logic       buf_bad,
    output logic       frame_err
);
    localparam int GAP_LIM   = PULSE_PER * GAP_PERIODS;
    localparam int NIB_DEPTH = 2 * MAX_BYTES;

    logic    fall;
    logic    nib_v, nib_err;
    nibble_t nib;
    logic    accept, reading, seg_done, seg_ok, seg_rec, ferr;
    logic    ovf, go;
    nibble_t out_nib;

    tpd_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .tape_in (tape_in),
        .fall_o  (fall)
    );

    tpd_burst #(.GAP_LIM(GAP_LIM)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_i    (fall),
        .nib_v_o   (nib_v),
        .nib_o     (nib),
        .nib_err_o (nib_err)
    );

    tpd_frame #(
        .START_CODE (START_CODE),
        .STOP_CODE  (STOP_CODE),
        .END_CODE   (END_CODE)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .nib_v_i   (nib_v),
        .nib_i     (nib),
        .nib_err_i (nib_err),
        .accept_o  (accept),
        .reading_o (reading),
        .done_o    (seg_done),
        .ok_o      (seg_ok),
        .rec_o     (seg_rec),
        .ferr_o    (ferr)
    );

    assign go = seg_done & seg_ok & ~ovf;

    tpd_store #(.DEPTH(NIB_DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (accept),
        .wr_nib_i  (nib),
        .go_i      (go),
        .ovf_o     (ovf),
        .out_v_o   (out_valid),
        .out_nib_o (out_nib)
    );

    assign motor_on  = reading;
    assign out_data  = {{(8 - NIB_W){1'b0}}, out_nib};
    assign buf_end   = seg_done;
    assign rec_end   = seg_done & seg_rec;
    assign buf_bad   = seg_done & ~go;
    assign frame_err = ferr;

    assert_quiet_while_reading_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !motor_on);
    assert_bad_has_no_stream_R9: assert property (@(posedge clk) disable iff (!rst_n)
        buf_bad |=> !out_valid);
    assert_motor_never_returns_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(motor_on) |-> buf_end);
endmodule

// File: tb/tape_burst_decoder_bench.sv
module tape_burst_decoder_bench;
    localparam int DEPTH = 368;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tape_in = 1'b1;
    logic       motor_on, out_valid, buf_end, rec_end, buf_bad, frame_err;
    logic [7:0] out_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model state
    logic [3:0] seg_nibs [$];
    logic [3:0] exp_q [$];
    int  m_bidx, m_srun, m_erun;
    bit  m_start_bad, m_ferr, m_done;
    int  seen_end, seen_rec, seen_bad;
    bit  prev_motor;

    always #4 clk = ~clk;

    tape_burst_decoder u_tape_burst_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .tape_in   (tape_in),
        .motor_on  (motor_on),
        .out_valid (out_valid),
        .out_data  (out_data),
        .buf_end   (buf_end),
        .rec_end   (rec_end),
        .buf_bad   (buf_bad),
        .frame_err (frame_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 R9 unexpected word", out_data, 0);
                end else begin
                    logic [3:0] e;
                    e = exp_q.pop_front();
                    check(out_data == {4'h0, e}, "R1 R2 R3 R8 word", out_data, {4'h0, e});
                end
                check(!motor_on, "R8 word while motor on", motor_on, 0);
            end
            if (buf_end) begin
                seen_end++;
                check(!motor_on, "R4 motor at end", motor_on, 0);
            end
            if (rec_end) seen_rec++;
            if (buf_bad) seen_bad++;
            if (!prev_motor && motor_on) check(1'b0, "R4 motor restarted", 1, 0);
            prev_motor = motor_on;
        end
    end

    task automatic reset_dut();
        @(posedge clk);
        tape_in <= 1'b1;
        rst_n   <= 1'b0;
        repeat (4) @(posedge clk);
        seg_nibs.delete();
        exp_q.delete();
        m_bidx = 0; m_srun = 0; m_erun = 0;
        m_start_bad = 0; m_ferr = 0; m_done = 0;
        seen_end = 0; seen_rec = 0; seen_bad = 0;
        prev_motor = 1'b1;
        rst_n <= 1'b1;
        repeat (2) @(posedge clk);
    endtask

    task automatic send_burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk) tape_in <= 1'b0;
            @(posedge clk);
            @(posedge clk) tape_in <= 1'b1;
            @(posedge clk);
        end
        repeat (20) @(posedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        if (!m_done) begin
            seg_nibs.push_back(b[7:4]);
            seg_nibs.push_back(b[3:0]);
            if (m_bidx < 2) begin
                if (b != 8'hA5) m_start_bad = 1;
                m_bidx++;
            end
            if (b == 8'hF0) m_srun++; else m_srun = 0;
            if (b == 8'hFE) m_erun++; else m_erun = 0;
            if (m_srun == 3 || m_erun == 3) begin
                m_done = 1;
                if (!m_start_bad && !m_ferr && seg_nibs.size() <= DEPTH)
                    foreach (seg_nibs[k]) exp_q.push_back(seg_nibs[k]);
            end
        end
        send_burst(int'(b[7:4]) + 1);
        send_burst(int'(b[3:0]) + 1);
    endtask

    task automatic send_overlong();
        if (!m_done) m_ferr = 1;
        send_burst(18);
    endtask

    task automatic settle_and_check(input string tag, input int e_end, input int e_rec,
                                    input int e_bad, input bit e_ferr);
        repeat (500) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, {tag, " R8 words missing"}, exp_q.size(), 0);
        check(seen_end == e_end, {tag, " R5 buf_end count"}, seen_end, e_end);
        check(seen_rec == e_rec, {tag, " R6 rec_end count"}, seen_rec, e_rec);
        check(seen_bad == e_bad, {tag, " R7 R9 buf_bad count"}, seen_bad, e_bad);
        check(frame_err == e_ferr, {tag, " R10 frame_err"}, frame_err, e_ferr);
        check(motor_on == (e_end == 0), {tag, " R4 motor"}, motor_on, (e_end == 0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        reset_dut();
        @(negedge clk);
        check(motor_on == 1'b1, "R4 reset motor", motor_on, 1);
        check(!out_valid && !buf_end && !buf_bad && !frame_err, "R4 reset outputs",
              {out_valid, buf_end, buf_bad, frame_err}, 0);

        // valid segment, broken stop run inside, then traffic after end (R5 R11)
        send_byte(8'hA5); send_byte(8'hA5);
        send_byte(8'h12); send_byte(8'h34);
        send_byte(8'hF0); send_byte(8'hF0); send_byte(8'h11);
        send_byte(8'hF0); send_byte(8'hF0); send_byte(8'hF0);
        send_byte(8'h56); send_overlong(); send_byte(8'hF0);
        settle_and_check("T_valid_R11", 1, 0, 0, 1'b0);

        // end-of-record triple
        reset_dut();
        send_byte(8'hA5); send_byte(8'hA5); send_byte(8'h0F);
        send_byte(8'hFE); send_byte(8'hF0); send_byte(8'hFE);
        send_byte(8'hFE); send_byte(8'hFE);
        settle_and_check("T_record_R6", 1, 1, 0, 1'b0);

        // missing second start word
        reset_dut();
        send_byte(8'hA5); send_byte(8'h33); send_byte(8'h44);
        send_byte(8'hF0); send_byte(8'hF0); send_byte(8'hF0);
        settle_and_check("T_nostart_R7", 1, 0, 1, 1'b0);

        // overlong burst between bytes
        reset_dut();
        send_byte(8'hA5); send_byte(8'hA5); send_overlong();
        send_byte(8'h9C);
        @(negedge clk);
        check(frame_err == 1'b1 && motor_on, "R10 frame_err mid segment", frame_err, 1);
        send_byte(8'hF0); send_byte(8'hF0); send_byte(8'hF0);
        settle_and_check("T_ferr_R10", 1, 0, 1, 1'b1);

        // exactly full store: valid
        reset_dut();
        send_byte(8'hA5); send_byte(8'hA5);
        for (int i = 0; i < DEPTH / 2 - 5; i++) send_byte(8'h00);
        send_byte(8'hF0); send_byte(8'hF0); send_byte(8'hF0);
        settle_and_check("T_full_R12", 1, 0, 0, 1'b0);

        // one byte too many: overflow
        reset_dut();
        send_byte(8'hA5); send_byte(8'hA5);
        for (int i = 0; i < DEPTH / 2 - 4; i++) send_byte(8'h00);
        send_byte(8'hF0); send_byte(8'hF0); send_byte(8'hF0);
        settle_and_check("T_overflow_R12", 1, 0, 1, 1'b0);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule